// File: doc/BRIEF.md
# Eight-Line Prioritised Interrupt Controller

This block gathers eight interrupt request lines and forwards the most urgent unmasked request to a processor on one interrupt output. Each line is edge- or level-sensitive by its own trigger-select input. The block keeps a request register, a mask register and an in-service register. A priority resolver picks the winner relative to a rotation offset, so priority can stay fixed or move round-robin. When the processor acknowledges, the block supplies a vector made from a programmed base and the winning line number.

Software drives the block through a synchronous byte port with one address bit. A command byte at address 0 with bit 4 set restarts the controller and opens a short programming sequence on address 1. Other command bytes at address 0 issue end-of-interrupt and rotation commands, or select readback and poll mode. Once programming is done, address 1 carries the mask. A poll read returns the current winner without an acknowledge cycle.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask, request and in-service registers, the rotation offset and all mode bits are zero: `intOut` is low, a read of address 1 returns 0x00 and a read of address 0 returns 0x00.
- R2: A write to address 0 with bit 4 set clears mask, request, in-service, offset, poll, readback select and both auto-EOI bits, and starts programming. Its bit 0 says whether a third programming byte follows. The next address-1 write loads the vector base. The one after either ends programming (bit 0 was 0) or moves on to a third byte whose bit 1 enables auto-EOI. After that, address-1 writes load the mask.
- R3: With `trigLevel[i]`=0, request bit i is set on a rising edge of `irqLines[i]` and stays set when the line falls. With `trigLevel[i]`=1, request bit i follows the line one cycle later.
- R4: A pending request whose mask bit is 1 cannot assert `intOut`. Clearing the mask bit lets it through.
- R5: Among unmasked requests, the line with the smallest (line − offset) mod 8 wins. `vector` is {base[7:3], line}.
- R6: A request asserts `intOut` only if its relative priority is strictly higher than that of the highest-priority in-service line.
- R7: An acknowledge (`intAck` high for one cycle) sets the winner's in-service bit when auto-EOI is off. It clears the winner's request bit only for an edge-triggered line.
- R8: A command byte with bits 4:3 = 00 and bits 7:5 = 001 clears the highest-priority in-service bit. Code 101 does the same and also sets the offset to that line + 1.
- R9: Code 011 clears the in-service bit named by bits 2:0. Code 111 also sets the offset to that line + 1. Code 110 sets the offset to bits 2:0 + 1, which makes that line the lowest priority.
- R10: With auto-EOI on, an acknowledge leaves the in-service register unchanged. Code 100 turns on rotate-on-auto-EOI and code 000 turns it off. While it is on, each acknowledge sets the offset to the acknowledged line + 1.
- R11: A command byte with bits 4:3 = 01 and bit 1 set selects the readback at address 0: bit 0 = 1 gives the in-service register, and bit 0 = 0 gives the request register. Address 1 reads the mask.
- R12: A command byte with bits 4:3 = 01 and bit 2 set arms poll. The next read at either address returns the winning line number, or 0x00 if there is none. That read clears the winner's in-service bit and disarms poll.
- R13: An acknowledge with no winner gives `vector` = {base[7:3], 3'd7} and changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (consumes a poll) |
| addr | input | 1 | Register address bit |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, combinational |
| irqLines | input | 8 | Interrupt request lines |
| trigLevel | input | 8 | Per-line trigger select, 1 = level |
| intOut | output | 1 | Interrupt to processor |
| intAck | input | 1 | Acknowledge strobe, one cycle |
| vector | output | 8 | Vector for current winner, combinational |

## Verification
The bench uses the package values of eight lines and a byte-wide port. With eight lines the three-bit offset wraps: the scenario rotates the offset to 3, 5, 7, 4, 6 and 3 again. This exercises cases where a numerically higher line beats a lower one. The byte port places the base in bits 7:3 of the vector. Two different bases are programmed, so the vector check covers both the base and the line field.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int NLINES = 8;
  localparam int LW     = $clog2(NLINES);
  localparam int DW     = 8;

  typedef struct packed {
    logic          initClr;
    logic          imrLoad;
    logic          eoiNonSpec;
    logic          eoiSpec;
    logic          rotOnEoi;
    logic          rotSet;
    logic [LW-1:0] lineSel;
    logic          pollRd;
    logic          ack;
  } strobe_t;
endpackage

// File: rtl/prio_irq_ctl.sv
module prio_irq_ctl
  import prio_irq_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic          addr,
  input  logic [DW-1:0] wrData,
  input  logic          intAck,
  output strobe_t       st,
  output logic          autoEoi,
  output logic          rotAeoi,
  output logic          pollArmed,
  output logic          readIsr,
  output logic [DW-1:0] base
);
  typedef enum logic [1:0] {STEP_IDLE, STEP_BASE, STEP_SECOND, STEP_THIRD} step_e;
  step_e step;
  logic  needThird;

  logic isInit, isSel, isCmd;
  logic [2:0] cmd;
  assign isInit = wrEn && !addr && wrData[4];
  assign isSel  = wrEn && !addr && !wrData[4] && wrData[3];
  assign isCmd  = wrEn && !addr && !wrData[4] && !wrData[3];
  assign cmd    = wrData[7:5];

  always_comb begin
    st            = '0;
    st.initClr    = isInit;
    st.imrLoad    = wrEn && addr && (step == STEP_IDLE);
    st.eoiNonSpec = isCmd && (cmd == 3'd1 || cmd == 3'd5);
    st.eoiSpec    = isCmd && (cmd == 3'd3 || cmd == 3'd7);
    st.rotOnEoi   = isCmd && cmd[2] && cmd[0];
    st.rotSet     = isCmd && (cmd == 3'd6);
    st.lineSel    = wrData[LW-1:0];
    st.pollRd     = rdEn && pollArmed;
    st.ack        = intAck;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      step <= STEP_IDLE; needThird <= 1'b0; base <= '0;
      autoEoi <= 1'b0; rotAeoi <= 1'b0; pollArmed <= 1'b0; readIsr <= 1'b0;
    end else begin
      if (rdEn && pollArmed) pollArmed <= 1'b0;
      if (isInit) begin
        step <= STEP_BASE; needThird <= wrData[0];
        autoEoi <= 1'b0; rotAeoi <= 1'b0; pollArmed <= 1'b0; readIsr <= 1'b0;
      end else if (wrEn && addr) begin
        case (step)
          STEP_BASE:   begin base <= wrData; step <= STEP_SECOND; end
          STEP_SECOND: step <= needThird ? STEP_THIRD : STEP_IDLE;
          STEP_THIRD:  begin autoEoi <= wrData[1]; step <= STEP_IDLE; end
          default:     ;
        endcase
      end else if (isSel) begin
        if (wrData[2]) pollArmed <= 1'b1;
        if (wrData[1]) readIsr <= wrData[0];
      end else if (isCmd && cmd[1:0] == 2'b00) begin
        rotAeoi <= cmd[2];
      end
    end
  end

  AST_INIT_RESETS_MODES: assert property (@(posedge clk) disable iff (!rstN)
    isInit |=> (!autoEoi && !rotAeoi && !pollArmed && !readIsr)); // R2
  AST_POLL_DISARM: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && pollArmed && !wrEn) |=> !pollArmed); // R12
endmodule

// File: rtl/prio_irq_dp.sv
module prio_irq_dp
  import prio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic [DW-1:0]     busData,
  input  logic              autoEoi,
  input  logic              rotAeoi,
  input  logic [NLINES-1:0] irqLines,
  input  logic [NLINES-1:0] trigLevel,
  output logic [NLINES-1:0] irr,
  output logic [NLINES-1:0] isr,
  output logic [NLINES-1:0] imr,
  output logic              winValid,
  output logic [LW-1:0]     winLine
);
  logic [LW-1:0]     offset;
  logic [NLINES-1:0] prevLines;
  logic [LW:0]       pendPri, isrPri;
  logic [LW-1:0]     isrLine;
  logic [NLINES-1:0] irrN, isrN, imrN;
  logic [LW-1:0]     offN;

  function automatic logic [LW:0] bestPri(input logic [NLINES-1:0] m, input logic [LW-1:0] off);
    logic [LW:0]   r;
    logic [LW-1:0] idx;
    r = (LW+1)'(NLINES);
    for (int p = NLINES - 1; p >= 0; p--) begin
      idx = LW'(p) + off;
      if (m[idx]) r = (LW+1)'(p);
    end
    return r;
  endfunction

  assign pendPri  = bestPri(irr & ~imr, offset);
  assign isrPri   = bestPri(isr, offset);
  assign winValid = pendPri < isrPri;
  assign winLine  = pendPri[LW-1:0] + offset;
  assign isrLine  = isrPri[LW-1:0] + offset;

  always_comb begin
    irrN = irr; isrN = isr; imrN = imr; offN = offset;
    if (st.ack && winValid) begin
      if (!trigLevel[winLine]) irrN[winLine] = 1'b0;
      if (autoEoi) begin
        if (rotAeoi) offN = winLine + LW'(1);
      end else begin
        isrN[winLine] = 1'b1;
      end
    end
    if (st.pollRd && winValid) isrN[winLine] = 1'b0;
    if (st.eoiNonSpec && !isrPri[LW]) begin
      isrN[isrLine] = 1'b0;
      if (st.rotOnEoi) offN = isrLine + LW'(1);
    end
    if (st.eoiSpec) begin
      isrN[st.lineSel] = 1'b0;
      if (st.rotOnEoi) offN = st.lineSel + LW'(1);
    end
    if (st.rotSet) offN = st.lineSel + LW'(1);
    if (st.imrLoad) imrN = busData[NLINES-1:0];
    for (int i = 0; i < NLINES; i++) begin
      if (trigLevel[i]) irrN[i] = irqLines[i];
      else if (irqLines[i] && !prevLines[i]) irrN[i] = 1'b1;
    end
    if (st.initClr) begin
      irrN = '0; isrN = '0; imrN = '0; offN = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irr <= '0; isr <= '0; imr <= '0; offset <= '0; prevLines <= '0;
    end else begin
      irr <= irrN; isr <= isrN; imr <= imrN; offset <= offN; prevLines <= irqLines;
    end
  end

  AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    st.initClr |=> (imr == '0 && isr == '0 && !winValid)); // R2
  AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (!rstN)
    !st.initClr |=> ((irr & $past(trigLevel)) == ($past(irqLines) & $past(trigLevel)))); // R3
  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    winValid |-> (|(irr & ~imr))); // R4
  AST_ACK_SETS_ISR: assert property (@(posedge clk) disable iff (!rstN)
    (st.ack && winValid && !autoEoi && !st.initClr && !st.eoiSpec && !st.eoiNonSpec && !st.pollRd)
    |=> isr[$past(winLine)]); // R7
  AST_AEOI_KEEPS_ISR: assert property (@(posedge clk) disable iff (!rstN)
    (st.ack && autoEoi && !st.initClr && !st.eoiSpec && !st.eoiNonSpec && !st.pollRd)
    |=> isr == $past(isr)); // R10
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              addr,
  input  logic [DW-1:0]     wrData,
  output logic [DW-1:0]     rdData,
  input  logic [NLINES-1:0] irqLines,
  input  logic [NLINES-1:0] trigLevel,
  output logic              intOut,
  input  logic              intAck,
  output logic [DW-1:0]     vector
);
  strobe_t           st;
  logic              autoEoi, rotAeoi, pollArmed, readIsr, winValid;
  logic [DW-1:0]     base;
  logic [NLINES-1:0] irr, isr, imr;
  logic [LW-1:0]     winLine;

  prio_irq_ctl u_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .intAck(intAck), .st(st), .autoEoi(autoEoi), .rotAeoi(rotAeoi),
    .pollArmed(pollArmed), .readIsr(readIsr), .base(base)
  );

  prio_irq_dp u_dp (
    .clk(clk), .rstN(rstN), .st(st), .busData(wrData), .autoEoi(autoEoi), .rotAeoi(rotAeoi),
    .irqLines(irqLines), .trigLevel(trigLevel), .irr(irr), .isr(isr), .imr(imr),
    .winValid(winValid), .winLine(winLine)
  );

  assign intOut = winValid;
  assign vector = {base[DW-1:LW], winValid ? winLine : LW'(NLINES - 1)};

  always_comb begin
    if (pollArmed)   rdData = winValid ? DW'(winLine) : '0;
    else if (addr)   rdData = DW'(imr);
    else if (readIsr) rdData = DW'(isr);
    else             rdData = DW'(irr);
  end
endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
  logic       clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, rdEn = 1'b0, addr = 1'b0, intAck = 1'b0;
  logic [7:0] wrData = '0, irqLines = '0, trigLevel = '0;
  logic [7:0] rdData, vector;
  logic       intOut;
  int         nChk = 0, nFail = 0, cyc = 0;
  logic [7:0] got;

  typedef struct { logic [7:0] v; string r; } exp_t;
  exp_t expQ[$];

  prio_irq_ctrl u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .irqLines(irqLines), .trigLevel(trigLevel), .intOut(intOut),
    .intAck(intAck), .vector(vector)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 5000) begin
      nFail++;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 5000)", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  task automatic pushExp(input logic [7:0] v, input string r);
    exp_t e; e.v = v; e.r = r; expQ.push_back(e);
  endtask

  task automatic observe(input logic [7:0] act);
    exp_t e = expQ.pop_front();
    nChk++;
    if (act !== e.v) begin
      nFail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", e.r, act, e.v);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(negedge clk); rdEn = 1'b1; addr = a; #1 v = rdData;
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic ack(output logic [7:0] v);
    @(negedge clk); intAck = 1'b1; #1 v = vector;
    @(negedge clk); intAck = 1'b0;
  endtask

  task automatic lines(input logic [7:0] v);
    @(negedge clk); irqLines = v;
    @(negedge clk);
  endtask

  task automatic chkInt(input logic e, input string r);
    @(negedge clk); #1 pushExp({7'd0, e}, r); observe({7'd0, intOut});
  endtask

  task automatic chkRd(input logic a, input logic [7:0] e, input string r);
    pushExp(e, r); rd(a, got); observe(got);
  endtask

  task automatic chkAck(input logic [7:0] e, input string r);
    pushExp(e, r); ack(got); observe(got);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chkInt(1'b0, "R1 intOut");
    chkRd(1'b1, 8'h00, "R1 mask");
    chkRd(1'b0, 8'h00, "R1 request");
    // R2 programming with third byte, no auto-EOI
    wr(0, 8'h11); wr(1, 8'h40); wr(1, 8'h00); wr(1, 8'h00); wr(1, 8'h00);
    // R3 edge
    lines(8'h08);
    chkRd(1'b0, 8'h08, "R3 R11 edge sets request");
    chkInt(1'b1, "R3 intOut");
    lines(8'h00);
    chkRd(1'b0, 8'h08, "R3 edge request held after fall");
    // R4 mask
    wr(1, 8'h08); chkInt(1'b0, "R4 masked");
    chkRd(1'b1, 8'h08, "R11 mask readback");
    wr(1, 8'h00); chkInt(1'b1, "R4 unmasked");
    // R5 priority
    lines(8'h20);
    chkAck(8'h43, "R5 line3 beats line5");
    wr(0, 8'h0B);
    chkRd(1'b0, 8'h08, "R7 R11 in-service set");
    chkInt(1'b0, "R6 lower request blocked");
    wr(0, 8'h20); chkInt(1'b1, "R8 EOI releases");
    chkAck(8'h45, "R5 line5");
    lines(8'h22);
    chkInt(1'b1, "R6 higher request nests");
    chkAck(8'h41, "R6 nested vector");
    wr(0, 8'h20);
    chkRd(1'b0, 8'h20, "R8 non-specific clears highest");
    wr(0, 8'h65);
    chkRd(1'b0, 8'h00, "R9 specific EOI");
    // R9 rotation
    wr(0, 8'hC2);
    lines(8'h36);
    chkAck(8'h44, "R9 set-lowest rotation");
    wr(0, 8'hE4);
    chkRd(1'b0, 8'h00, "R9 specific EOI rotate clears");
    lines(8'h76);
    chkAck(8'h46, "R9 rotated offset 5");
    wr(0, 8'hA0);
    chkRd(1'b0, 8'h00, "R8 non-specific rotate clears");
    // R3 level, R7 ack keeps level request
    trigLevel = 8'h01;
    lines(8'h77);
    chkAck(8'h40, "R8 rotated offset 7, line0 wins");
    wr(0, 8'h0A);
    chkRd(1'b0, 8'h05, "R7 level request kept");
    lines(8'h76);
    chkRd(1'b0, 8'h04, "R3 level request follows line");
    wr(0, 8'h20); wr(0, 8'h0B);
    chkRd(1'b0, 8'h00, "R8 level line EOI");
    // R12 poll
    wr(0, 8'h0C);
    chkRd(1'b1, 8'h02, "R12 poll returns winner");
    chkRd(1'b0, 8'h00, "R12 poll disarmed");
    chkAck(8'h42, "R5 line2");
    wr(0, 8'h0C);
    chkRd(1'b0, 8'h00, "R12 poll with no winner");
    chkRd(1'b0, 8'h04, "R12 empty poll leaves in-service");
    wr(0, 8'h62);
    // R2 re-init with auto-EOI
    wr(1, 8'h80);
    wr(0, 8'h11); wr(1, 8'h40); wr(1, 8'h00); wr(1, 8'h02);
    chkRd(1'b1, 8'h00, "R2 init clears mask");
    chkRd(1'b0, 8'h00, "R2 init clears request");
    chkInt(1'b0, "R2 intOut after init");
    // R10 auto-EOI with rotation
    wr(0, 8'h80);
    lines(8'h7E);
    chkAck(8'h43, "R10 auto-EOI ack");
    wr(0, 8'h0B);
    chkRd(1'b0, 8'h00, "R10 in-service untouched");
    lines(8'h00); lines(8'h24);
    chkAck(8'h45, "R10 rotate on auto-EOI");
    chkAck(8'h42, "R10 remaining line");
    chkInt(1'b0, "R13 nothing pending");
    chkAck(8'h47, "R13 spurious vector");
    chkRd(1'b0, 8'h00, "R13 no in-service change");
    // R2 programming without third byte
    wr(0, 8'h10); wr(1, 8'h80); wr(1, 8'h00); wr(1, 8'hFF);
    chkRd(1'b1, 8'hFF, "R2 short sequence then mask");
    wr(1, 8'h00);
    lines(8'h00); lines(8'h40);
    chkAck(8'h86, "R2 new base in vector");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule